// File: doc/BRIEF.md
# Stack-Relative Load Address Unit

This unit decodes a 16-bit instruction that loads a word from memory at a stack-pointer-relative address, and runs that load. The base is the 24-bit stack pointer. The 7-bit displacement held in the load can be widened by up to two prefix instructions that arrive just before it. A single prefix supplies displacement bits 19:7. Two prefixes supply bits 23:20 (from the older one) and bits 19:7 (from the newer one).

Instructions arrive one halfword per cycle with a valid strobe. An accepted load spends one cycle issuing a read with a word-aligned address. In the next cycle it writes the low 24 bits of the returned word into the destination register. If the computed address is not a multiple of four, a misalignment interrupt request pulses alongside the read. The read still goes ahead with the two low address bits cleared. A load marked as sitting in a branch delay slot ignores any pending prefix.

Top module: `sp_load_agu`

## Requirements
- R1: A halfword accepted with bits 15:10 equal to 111011 is a load. The cycle after acceptance, `mem_rd` is high for exactly one cycle, and `rf_waddr` carries bits 9:7 of the load.
- R2: With no pending prefix, the effective address is `sp` plus bits 6:0 of the load, zero-extended to 24 bits.
- R3: A prefix is a halfword with bits 15:13 equal to 110, and its bits 12:0 are its immediate. With one pending prefix, the displacement is {4'b0, prefix immediate, load bits 6:0}.
- R4: With two pending prefixes, the displacement is {older prefix bits 3:0, newer prefix immediate, load bits 6:0}. When more than two prefixes arrive in a row, only the last two count.
- R5: The address sum is taken modulo 2^24, so any carry out of bit 23 is dropped.
- R6: `mem_addr` always has bits 1:0 cleared. `misalign_irq` is high in the read cycle exactly when the effective address has a nonzero bit 1 or bit 0.
- R7: A load accepted with `in_delay_slot` high uses only its 7-bit displacement, and it still clears the pending prefixes.
- R8: Any accepted halfword that is not a prefix clears the pending prefixes, whether or not it is a load.
- R9: In the cycle after the read cycle, `rf_we` is high for one cycle, and `rf_wdata` equals `mem_rdata` bits 23:0.
- R10: `instr_ready` is low during the read cycle. A halfword presented in that cycle is not accepted and has no effect on the prefix state.
- R11: After reset, `mem_rd`, `misalign_irq` and `rf_we` are low, `instr_ready` is high, and no prefix is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Halfword on `instr` is valid |
| instr | input | 16 | Instruction halfword |
| in_delay_slot | input | 1 | The presented halfword sits in a branch delay slot |
| instr_ready | output | 1 | Unit can accept a halfword this cycle |
| sp | input | 24 | Stack pointer value |
| mem_rd | output | 1 | Word read request |
| mem_addr | output | 24 | Word-aligned read address |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |
| misalign_irq | output | 1 | Misaligned-address interrupt request |
| rf_we | output | 1 | Destination register write enable |
| rf_waddr | output | 3 | Destination register index |
| rf_wdata | output | 24 | Data written to the destination register |

## Verification
Corrupted prefix state only becomes visible at the ports on the next load. It appears as a wrong `mem_addr` in that load's read cycle, one cycle after acceptance. For that reason every prefix sequence, every clearing instruction and every stalled prefix in the bench is followed by a load whose address is checked. A fault in the sequencer shows up within two cycles: `mem_rd`, `rf_we` or `instr_ready` land in the wrong cycle. Misalignment errors appear in the same read cycle, as a wrong interrupt pulse or as low address bits that are not cleared.

// File: rtl/sld_pkg.sv
package sld_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_WB   = 2'd2
   } seq_state_t;

   localparam int          OPC_W    = 6;
   localparam logic [5:0]  LOAD_OPC = 6'b111011;
   localparam int          PTAG_W   = 3;
   localparam logic [2:0]  PFX_OPC  = 3'b110;
endpackage

// File: rtl/sld_prefix_acc.sv
module sld_prefix_acc #(
   parameter int PFX_W = 13,
   parameter int HI_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pfx_push,
   input  logic [PFX_W-1:0] pfx_imm,
   input  logic             pfx_clear,
   output logic [1:0]       pfx_cnt,
   output logic [HI_W-1:0]  pfx_older,
   output logic [PFX_W-1:0] pfx_newer
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pfx_cnt   <= 2'd0;
         pfx_older <= '0;
         pfx_newer <= '0;
      end else if (pfx_push) begin
         pfx_older <= pfx_newer[HI_W-1:0];
         pfx_newer <= pfx_imm;
         if (pfx_cnt != 2'd2) pfx_cnt <= pfx_cnt + 2'd1;
      end else if (pfx_clear) begin
         pfx_cnt   <= 2'd0;
         pfx_older <= '0;
         pfx_newer <= '0;
      end
   end
endmodule

// File: rtl/sld_disp_addr.sv
module sld_disp_addr #(
   parameter int ADDR_W = 24,
   parameter int DISP_W = 7,
   parameter int PFX_W  = 13,
   parameter int HI_W   = 4
) (
   input  logic [ADDR_W-1:0] sp,
   input  logic [DISP_W-1:0] disp_lo,
   input  logic              use_pfx,
   input  logic [1:0]        pfx_cnt,
   input  logic [HI_W-1:0]   pfx_older,
   input  logic [PFX_W-1:0]  pfx_newer,
   output logic [ADDR_W-1:0] eff_addr
);
   localparam int PAD0_W = ADDR_W - DISP_W;

   logic [ADDR_W-1:0] disp;

   always_comb begin
      disp = {{PAD0_W{1'b0}}, disp_lo};
      if (use_pfx) begin
         case (pfx_cnt)
            2'd1:    disp = {{HI_W{1'b0}}, pfx_newer, disp_lo};
            2'd2:    disp = {pfx_older, pfx_newer, disp_lo};
            default: disp = {{PAD0_W{1'b0}}, disp_lo};
         endcase
      end
   end

   assign eff_addr = sp + disp;
endmodule

// File: rtl/sld_load_seq.sv
module sld_load_seq
   import sld_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int RSEL_W     = 3,
   parameter int ALIGN_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_load,
   input  logic [ADDR_W-1:0] eff_addr,
   input  logic [RSEL_W-1:0] dst_sel,
   output logic              ready,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              misalign_irq,
   output logic              rf_we,
   output logic [RSEL_W-1:0] rf_waddr
);
   seq_state_t        state_q, state_d;
   logic [ADDR_W-1:0] eff_q;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: if (accept_load) state_d = ST_ADDR;
         ST_ADDR: state_d = ST_WB;
         ST_WB:   state_d = accept_load ? ST_ADDR : ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         eff_q    <= '0;
         rf_waddr <= '0;
      end else begin
         state_q <= state_d;
         if (accept_load) begin
            eff_q    <= eff_addr;
            rf_waddr <= dst_sel;
         end
      end
   end

   assign ready  = (state_q != ST_ADDR);
   assign mem_rd = (state_q == ST_ADDR);
   assign rf_we  = (state_q == ST_WB);

   generate
      if (ALIGN_BITS > 0) begin : g_align
         assign mem_addr     = {eff_q[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
         assign misalign_irq = mem_rd && (|eff_q[ALIGN_BITS-1:0]);
      end else begin : g_noalign
         assign mem_addr     = eff_q;
         assign misalign_irq = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/sp_load_agu.sv
module sp_load_agu
   import sld_pkg::*;
#(
   parameter int INSN_W     = 16,
   parameter int ADDR_W     = 24,
   parameter int DISP_W     = 7,
   parameter int PFX_W      = 13,
   parameter int HI_W       = 4,
   parameter int RSEL_W     = 3,
   parameter int DATA_W     = 32,
   parameter int REG_W      = 24,
   parameter int ALIGN_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [INSN_W-1:0] instr,
   input  logic              in_delay_slot,
   output logic              instr_ready,
   input  logic [ADDR_W-1:0] sp,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              misalign_irq,
   output logic              rf_we,
   output logic [RSEL_W-1:0] rf_waddr,
   output logic [REG_W-1:0]  rf_wdata
);
   localparam int RSEL_LSB = DISP_W;
   localparam int RSEL_MSB = DISP_W + RSEL_W - 1;
   localparam int OPC_LSB  = INSN_W - OPC_W;
   localparam int PTAG_LSB = INSN_W - PTAG_W;

   generate
      if (DISP_W + PFX_W + HI_W != ADDR_W) begin : g_bad_disp
         $error("displacement fields must add up to ADDR_W");
      end
      if (OPC_LSB != DISP_W + RSEL_W) begin : g_bad_fmt
         $error("load format does not fill the instruction");
      end
      if (PTAG_LSB != PFX_W) begin : g_bad_pfx
         $error("prefix immediate width does not fit the instruction");
      end
      if (REG_W > DATA_W || HI_W > PFX_W || HI_W < 1) begin : g_bad_w
         $error("register or prefix width out of range");
      end
      if (ALIGN_BITS >= ADDR_W) begin : g_bad_align
         $error("ALIGN_BITS too large");
      end
   endgenerate

   logic              accept, is_load, is_pfx;
   logic [1:0]        pfx_cnt;
   logic [HI_W-1:0]   pfx_older;
   logic [PFX_W-1:0]  pfx_newer;
   logic [ADDR_W-1:0] eff_addr;

   assign accept  = instr_valid && instr_ready;
   assign is_load = (instr[INSN_W-1:OPC_LSB] == LOAD_OPC);
   assign is_pfx  = (instr[INSN_W-1:PTAG_LSB] == PFX_OPC);

   sld_prefix_acc #(.PFX_W(PFX_W), .HI_W(HI_W)) i_pfx (
      .clk       (clk),
      .rst_n     (rst_n),
      .pfx_push  (accept && is_pfx),
      .pfx_imm   (instr[PFX_W-1:0]),
      .pfx_clear (accept && !is_pfx),
      .pfx_cnt   (pfx_cnt),
      .pfx_older (pfx_older),
      .pfx_newer (pfx_newer)
   );

   sld_disp_addr #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .PFX_W(PFX_W), .HI_W(HI_W)) i_addr (
      .sp        (sp),
      .disp_lo   (instr[DISP_W-1:0]),
      .use_pfx   (!in_delay_slot),
      .pfx_cnt   (pfx_cnt),
      .pfx_older (pfx_older),
      .pfx_newer (pfx_newer),
      .eff_addr  (eff_addr)
   );

   sld_load_seq #(.ADDR_W(ADDR_W), .RSEL_W(RSEL_W), .ALIGN_BITS(ALIGN_BITS)) i_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .accept_load  (accept && is_load),
      .eff_addr     (eff_addr),
      .dst_sel      (instr[RSEL_MSB:RSEL_LSB]),
      .ready        (instr_ready),
      .mem_rd       (mem_rd),
      .mem_addr     (mem_addr),
      .misalign_irq (misalign_irq),
      .rf_we        (rf_we),
      .rf_waddr     (rf_waddr)
   );

   assign rf_wdata = mem_rdata[REG_W-1:0];
endmodule

// File: rtl/sld_checker.sv
module sld_checker #(
   parameter int INSN_W = 16,
   parameter int ADDR_W = 24,
   parameter int RSEL_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              instr_valid,
   input logic [INSN_W-1:0] instr,
   input logic              instr_ready,
   input logic              mem_rd,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              misalign_irq,
   input logic              rf_we,
   input logic [RSEL_W-1:0] rf_waddr
);
   AST_LOAD_STARTS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && instr_ready && instr[INSN_W-1:INSN_W-6] == 6'b111011) |=> mem_rd); // R1
   AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd); // R1
   AST_ADDR_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> (mem_addr[1:0] == 2'b00)); // R6
   AST_IRQ_ONLY_WITH_READ: assert property (@(posedge clk) disable iff (!rst_n)
      misalign_irq |-> mem_rd); // R6
   AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> (rf_we && $stable(rf_waddr))); // R9
   AST_WRITE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> $past(mem_rd)); // R9
   AST_STALL_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> !instr_ready); // R10
endmodule

bind sp_load_agu sld_checker #(.INSN_W(INSN_W), .ADDR_W(ADDR_W), .RSEL_W(RSEL_W)) i_sld_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .instr_valid  (instr_valid),
   .instr        (instr),
   .instr_ready  (instr_ready),
   .mem_rd       (mem_rd),
   .mem_addr     (mem_addr),
   .misalign_irq (misalign_irq),
   .rf_we        (rf_we),
   .rf_waddr     (rf_waddr)
);

// File: tb/test_sp_load_agu.sv
`timescale 1ns/1ps
module test_sp_load_agu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [15:0] instr = '0;
   logic        in_delay_slot = 1'b0;
   logic        instr_ready;
   logic [23:0] sp = '0;
   logic        mem_rd;
   logic [23:0] mem_addr;
   logic [31:0] mem_rdata = '0;
   logic        misalign_irq;
   logic        rf_we;
   logic [2:0]  rf_waddr;
   logic [23:0] rf_wdata;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // model of pending prefixes
   int          m_cnt = 0;
   logic [3:0]  m_old = '0;
   logic [12:0] m_new = '0;

   always #2.5 clk = ~clk;

   sp_load_agu i_sp_load_agu (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
      .in_delay_slot(in_delay_slot), .instr_ready(instr_ready), .sp(sp),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .misalign_irq(misalign_irq), .rf_we(rf_we), .rf_waddr(rf_waddr),
      .rf_wdata(rf_wdata)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] exp_addr(input logic [23:0] s, input logic [6:0] lo, input bit ds);
      logic [23:0] d;
      d = {17'b0, lo};
      if (!ds && m_cnt == 1) d = {4'b0, m_new, lo};
      if (!ds && m_cnt == 2) d = {m_old, m_new, lo};
      return s + d;
   endfunction

   // drive one halfword for one cycle (entered and left at a negedge)
   task automatic send(input logic [15:0] h, input bit ds);
      instr = h; in_delay_slot = ds; instr_valid = 1'b1;
      @(negedge clk);
      instr_valid = 1'b0; in_delay_slot = 1'b0;
   endtask

   task automatic prefix(input logic [12:0] imm);
      send({3'b110, imm}, 1'b0);
      m_old = m_new[3:0];
      m_new = imm;
      if (m_cnt < 2) m_cnt++;
   endtask

   task automatic other(input logic [12:0] low);
      send({3'b000, low}, 1'b0);
      m_cnt = 0; m_old = '0; m_new = '0;
   endtask

   task automatic load(input logic [2:0] rd, input logic [6:0] lo, input bit ds,
                       input logic [23:0] s, input bit stall_pfx);
      logic [23:0] e;
      logic [31:0] w;
      sp = s;
      e = exp_addr(s, lo, ds);
      send({6'b111011, rd, lo}, ds);
      m_cnt = 0; m_old = '0; m_new = '0;
      // read cycle
      chk(mem_rd === 1'b1, "R1 mem_rd", 32'(mem_rd), 1);
      chk(rf_waddr === rd, "R1 rf_waddr", 32'(rf_waddr), 32'(rd));
      chk(mem_addr === {e[23:2], 2'b00}, "R2-R7 mem_addr", 32'(mem_addr), 32'({e[23:2], 2'b00}));
      chk(misalign_irq === (e[1:0] != 2'b00), "R6 misalign_irq", 32'(misalign_irq), 32'(e[1:0] != 2'b00));
      chk(instr_ready === 1'b0, "R10 instr_ready", 32'(instr_ready), 0);
      w = $urandom;
      mem_rdata = w;
      if (stall_pfx) begin
         instr = {3'b110, 13'h1fff}; instr_valid = 1'b1; // R10: must not be taken
      end
      @(negedge clk);
      instr_valid = 1'b0;
      chk(rf_we === 1'b1 && mem_rd === 1'b0, "R9 rf_we", 32'({rf_we, mem_rd}), 32'h2);
      chk(rf_wdata === w[23:0], "R9 rf_wdata", 32'(rf_wdata), 32'(w[23:0]));
      @(negedge clk);
      chk(rf_we === 1'b0, "R9 rf_we single", 32'(rf_we), 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(mem_rd === 1'b0 && rf_we === 1'b0 && misalign_irq === 1'b0, "R11 outputs",
          32'({mem_rd, rf_we, misalign_irq}), 0);
      chk(instr_ready === 1'b1, "R11 ready", 32'(instr_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: no prefix pending after reset
      load(3'd5, 7'h10, 1'b0, 24'h000100, 1'b0);
      // R3 worked case: prefix 0x1, displacement 0x4 -> sp + 0x84
      prefix(13'h1);
      load(3'd0, 7'h04, 1'b0, 24'h001000, 1'b0);
      chk(m_cnt == 0, "R3 model", 32'(m_cnt), 0);
      // R4 two prefixes
      prefix(13'h00a);
      prefix(13'h1234);
      load(3'd7, 7'h7c, 1'b0, 24'h100000, 1'b0);
      // R4 three prefixes: last two count
      prefix(13'h005); prefix(13'h003); prefix(13'h0ff0);
      load(3'd1, 7'h00, 1'b0, 24'h0, 1'b0);
      // R5 wraparound
      prefix(13'hf); prefix(13'h1fff);
      load(3'd2, 7'h7f, 1'b0, 24'hffff80, 1'b0);
      // R6 misaligned
      load(3'd3, 7'h01, 1'b0, 24'h000200, 1'b0);
      load(3'd4, 7'h02, 1'b0, 24'h000201, 1'b0);
      // R7 delay slot ignores and clears prefixes
      prefix(13'h0aa);
      load(3'd6, 7'h08, 1'b1, 24'h000400, 1'b0);
      load(3'd6, 7'h08, 1'b0, 24'h000400, 1'b0);
      // R8 non-prefix instruction clears
      prefix(13'h155);
      other(13'h0042);
      load(3'd1, 7'h0c, 1'b0, 24'h002000, 1'b0);
      // R10 halfword in read cycle is ignored
      load(3'd2, 7'h04, 1'b0, 24'h003000, 1'b1);
      load(3'd2, 7'h04, 1'b0, 24'h003000, 1'b0);
      // random mix
      for (int i = 0; i < 400; i++) begin
         int np;
         np = $urandom_range(0, 3);
         for (int k = 0; k < np; k++) prefix(13'($urandom));
         if ($urandom_range(0, 7) == 0) other(13'($urandom));
         load(3'($urandom), 7'($urandom), ($urandom_range(0, 5) == 0), 24'($urandom),
              ($urandom_range(0, 9) == 0));
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule